// File: doc/BRIEF.md
# Threshold-Gated Sensor Scheme Selector

This block serves a small set of sensor channels. Each channel owns a bank of fixed processing schemes that are all built into the logic from reset. A per-channel select code picks, through a multiplexer, which scheme result is taken. Changing the select therefore loads nothing and costs no extra cycle: the new code is used at the very next sample edge.

Every channel has a programmable threshold. A raw reading strictly above the threshold marks the channel as taking part in fusion. A fusion stage averages the processed values of the taking-part channels into one word. It also reports a valid flag and a mask of the channels that contributed.

Each channel behaves as an agent with a control port. Pulses on activate and deactivate switch it on and off. It raises a one-cycle done flag for every sample it processes. A switched-off agent ignores samples, keeps its last result and activity flag, and stays out of the fused result until it is switched on again.

Top module: `sensor_scheme_selector`

## Requirements
- R1: After reset all outputs are zero, every threshold is zero and every agent is switched off.
- R2: With cfg_we high at a clock edge, cfg_wdata is written to the threshold of the channel numbered by cfg_addr.
- R3: At a sample edge (sample_valid high), an enabled channel is marked active when its raw value is strictly greater than its threshold; equal or below marks it inactive.
- R4: Scheme codes: 0 passes the raw value, 1 shifts it right by one, 2 doubles it with saturation at 0xFFFF, 3 takes the bitwise complement. Channel i uses the raw value at sample_data[16*i +: 16] and the code at scheme_sel[2*i +: 2].
- R5: The select code present at a sample edge is the one applied. The fused word built from that sample appears after the next clock edge, and a code change adds no further cycle.
- R6: Each cycle, the fusion register takes the truncated mean of the processed values of channels that are both enabled and active. active_mask bit i reports channel i as contributing.
- R7: When no channel contributes, fused_valid is low and fused_data keeps its previous value.
- R8: A pulse on agent_activate[i] enables channel i from the next edge, and a pulse on agent_deactivate[i] disables it. When both are high, deactivate wins.
- R9: A disabled channel ignores samples and keeps its processed value and activity flag. Once enabled again, those held values rejoin fusion without a new sample.
- R10: agent_done[i] is high for the one cycle after a sample edge at which channel i was enabled, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sample_valid | input | 1 | Strobe marking a new set of raw readings |
| sample_data | input | 64 | Raw readings, 16 bits per channel |
| scheme_sel | input | 8 | Scheme code, 2 bits per channel |
| cfg_we | input | 1 | Threshold write enable |
| cfg_addr | input | 2 | Channel whose threshold is written |
| cfg_wdata | input | 16 | Threshold value |
| agent_activate | input | 4 | Per-channel enable pulse |
| agent_deactivate | input | 4 | Per-channel disable pulse |
| agent_done | output | 4 | Per-channel one-cycle processed flag |
| fused_data | output | 16 | Mean of contributing processed values |
| fused_valid | output | 1 | High when at least one channel contributed |
| active_mask | output | 4 | Channels that contributed to fused_data |

## Verification
The bench uses the default build of four channels, four schemes and 16-bit data. With four channels, contributor counts of one, two, three and four all occur, so the truncating divide by three is exercised. Every scheme code can also be placed on a different channel in one sample. The 16-bit width puts the doubling saturation and the complement near 0xFFFF within reach, and a threshold of 0xFFFF shuts a channel out for any reading.

// File: rtl/sensor_scheme_selector.sv
module sensor_scheme_selector #(
  parameter int NUM_CH  = 4,
  parameter int NUM_SCH = 4,
  parameter int DW      = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          sample_valid,
  input  logic [NUM_CH*DW-1:0]          sample_data,
  input  logic [NUM_CH*$clog2(NUM_SCH)-1:0] scheme_sel,
  input  logic                          cfg_we,
  input  logic [$clog2(NUM_CH)-1:0]     cfg_addr,
  input  logic [DW-1:0]                 cfg_wdata,
  input  logic [NUM_CH-1:0]             agent_activate,
  input  logic [NUM_CH-1:0]             agent_deactivate,
  output logic [NUM_CH-1:0]             agent_done,
  output logic [DW-1:0]                 fused_data,
  output logic                          fused_valid,
  output logic [NUM_CH-1:0]             active_mask
);
  localparam int SW   = $clog2(NUM_SCH);
  localparam int SUMW = DW + $clog2(NUM_CH) + 1;

  logic [DW-1:0]     thr_q  [NUM_CH];
  logic [DW-1:0]     proc_q [NUM_CH];
  logic [NUM_CH-1:0] en_q, act_q, done_q, mask_q;
  logic [DW-1:0]     fused_q;
  logic              fvalid_q;
  logic [NUM_CH-1:0] contrib;
  logic [SUMW-1:0]   sum, cnt, mean;

  function automatic logic [DW-1:0] run_scheme(input logic [SW-1:0] code, input logic [DW-1:0] x);
    case (code)
      SW'(1):  return x >> 1;
      SW'(2):  return x[DW-1] ? {DW{1'b1}} : (x << 1);
      SW'(3):  return ~x;
      default: return x;
    endcase
  endfunction

  assign contrib = en_q & act_q;

  always_ff @(posedge clk) begin
    if (!rst_n) en_q <= '0;
    else        en_q <= (en_q | agent_activate) & ~agent_deactivate;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_CH; i++) thr_q[i] <= '0;
    end else if (cfg_we) begin
      thr_q[cfg_addr] <= cfg_wdata;
    end
  end

  genvar g;
  generate
    for (g = 0; g < NUM_CH; g++) begin : g_ch
      logic [DW-1:0] raw;
      logic [SW-1:0] code;
      assign raw  = sample_data[g*DW +: DW];
      assign code = scheme_sel[g*SW +: SW];

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          proc_q[g] <= '0;
          act_q[g]  <= 1'b0;
          done_q[g] <= 1'b0;
        end else begin
          done_q[g] <= en_q[g] & sample_valid;
          if (en_q[g] && sample_valid) begin
            proc_q[g] <= run_scheme(code, raw);
            act_q[g]  <= raw > thr_q[g];
          end
        end
      end

      // R9
      hold_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(en_q[g]) |-> ($stable(proc_q[g]) && $stable(act_q[g])));

      // R10
      done_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        agent_done[g] |-> $past(en_q[g] && sample_valid));
    end
  endgenerate

  always_comb begin
    sum = '0;
    cnt = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (contrib[i]) begin
        sum = sum + SUMW'(proc_q[i]);
        cnt = cnt + SUMW'(1);
      end
    end
    mean = (cnt == '0) ? '0 : sum / cnt;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fused_q  <= '0;
      fvalid_q <= 1'b0;
      mask_q   <= '0;
    end else begin
      fvalid_q <= |contrib;
      mask_q   <= contrib;
      if (|contrib) fused_q <= mean[DW-1:0];
    end
  end

  assign agent_done  = done_q;
  assign fused_data  = fused_q;
  assign fused_valid = fvalid_q;
  assign active_mask = mask_q;

  // R2
  thr_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cfg_we) |-> thr_q[$past(cfg_addr)] == $past(cfg_wdata));

  // R6
  valid_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fused_valid == (active_mask != '0));

  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fused_valid |-> $stable(fused_data));

endmodule

// File: tb/sensor_scheme_selector_bench.sv
`timescale 1ns/1ps
module sensor_scheme_selector_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sample_valid = 1'b0;
  logic [63:0] sample_data = '0;
  logic [7:0]  scheme_sel = '0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_addr = '0;
  logic [15:0] cfg_wdata = '0;
  logic [3:0]  agent_activate = '0;
  logic [3:0]  agent_deactivate = '0;
  logic [3:0]  agent_done;
  logic [15:0] fused_data;
  logic        fused_valid;
  logic [3:0]  active_mask;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  sensor_scheme_selector u_sensor_scheme_selector (
    .clk(clk), .rst_n(rst_n), .sample_valid(sample_valid), .sample_data(sample_data),
    .scheme_sel(scheme_sel), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .agent_activate(agent_activate), .agent_deactivate(agent_deactivate),
    .agent_done(agent_done), .fused_data(fused_data), .fused_valid(fused_valid),
    .active_mask(active_mask)
  );

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic set_thr(input int ch, input logic [15:0] v);
    @(negedge clk); cfg_we = 1'b1; cfg_addr = ch[1:0]; cfg_wdata = v;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic set_all_thr(input logic [15:0] v);
    for (int i = 0; i < 4; i++) set_thr(i, v);
  endtask

  task automatic pulse(input logic [3:0] on, input logic [3:0] off);
    @(negedge clk); agent_activate = on; agent_deactivate = off;
    @(negedge clk); agent_activate = '0; agent_deactivate = '0;
  endtask

  // drives one sample; returns after the fused register has taken it
  task automatic sample(input logic [15:0] a, b, c, d, input logic [7:0] sel, output logic [3:0] done_seen);
    @(negedge clk); sample_data = {d, c, b, a}; scheme_sel = sel; sample_valid = 1'b1;
    @(negedge clk); sample_valid = 1'b0; done_seen = agent_done;
    @(negedge clk);
  endtask

  task automatic test_reset();
    check("R1", "fused_valid", 32'(fused_valid), 0);
    check("R1", "fused_data", 32'(fused_data), 0);
    check("R1", "active_mask", 32'(active_mask), 0);
    check("R1", "agent_done", 32'(agent_done), 0);
  endtask

  task automatic test_all_pass();
    logic [3:0] d;
    set_all_thr(16'd100);
    pulse(4'hF, 4'h0);
    sample(16'd200, 16'd300, 16'd400, 16'd500, 8'h00, d);
    check("R10", "done all", 32'(d), 32'hF);
    check("R6", "mean of four", 32'(fused_data), 350);
    check("R6", "mask four", 32'(active_mask), 32'hF);
    check("R6", "valid", 32'(fused_valid), 1);
    check("R10", "done drops", 32'(agent_done), 0);
  endtask

  task automatic test_boundary();
    logic [3:0] d;
    sample(16'd100, 16'd101, 16'd50, 16'd1000, 8'h00, d);
    check("R3", "equal is inactive", 32'(active_mask), 32'b1010);
    check("R3", "mean of two", 32'(fused_data), (101 + 1000) / 2);
  endtask

  task automatic test_schemes();
    logic [3:0] d;
    set_all_thr(16'd0);
    sample(16'd1001, 16'h9000, 16'h00FF, 16'd7, {2'd0, 2'd3, 2'd2, 2'd1}, d);
    check("R4", "four schemes", 32'(fused_data), (500 + 65535 + 65280 + 7) / 4);
    sample(16'h7FFF, 16'h7FFF, 16'h7FFF, 16'h7FFF, {4{2'd2}}, d);
    check("R4", "double no saturate", 32'(fused_data), 32'hFFFE);
  endtask

  task automatic test_div3();
    logic [3:0] d;
    set_thr(3, 16'hFFFF);
    sample(16'd10, 16'd11, 16'd13, 16'hFFFF, 8'h00, d);
    check("R6", "mask three", 32'(active_mask), 32'b0111);
    check("R6", "truncated mean of three", 32'(fused_data), 11);
    set_thr(3, 16'd0);
  endtask

  task automatic test_switch();
    logic [3:0] d;
    sample(16'd1000, 16'd1000, 16'd1000, 16'd1000, 8'h00, d);
    check("R5", "before switch", 32'(fused_data), 1000);
    sample(16'd1000, 16'd1000, 16'd1000, 16'd1000, 8'hFF, d);
    check("R5", "after switch", 32'(fused_data), 65535 - 1000);
  endtask

  task automatic test_none();
    logic [3:0] d;
    logic [15:0] prev;
    prev = fused_data;
    set_all_thr(16'hFFFF);
    sample(16'd5, 16'd6, 16'd7, 16'hFFFF, 8'h00, d);
    check("R7", "valid low", 32'(fused_valid), 0);
    check("R7", "mask empty", 32'(active_mask), 0);
    check("R7", "data held", 32'(fused_data), 32'(prev));
  endtask

  task automatic test_agents();
    logic [3:0] d;
    set_all_thr(16'd0);
    sample(16'd40, 16'd40, 16'd40, 16'd40, 8'h00, d);
    check("R6", "all forty", 32'(fused_data), 40);
    pulse(4'h0, 4'h1);
    sample(16'd1000, 16'd1000, 16'd1000, 16'd1000, 8'h00, d);
    check("R9", "off channel no done", 32'(d), 32'b1110);
    check("R8", "off channel out of mask", 32'(active_mask), 32'b1110);
    check("R9", "mean without off channel", 32'(fused_data), 1000);
    pulse(4'h1, 4'h0);
    @(negedge clk);
    check("R9", "held value rejoins", 32'(fused_data), (40 + 3000) / 4);
    check("R8", "reactivated mask", 32'(active_mask), 32'hF);
    pulse(4'h2, 4'h2);
    sample(16'd8, 16'd8, 16'd8, 16'd8, 8'h00, d);
    check("R8", "deactivate wins", 32'(d), 32'b1101);
    check("R8", "mask after both", 32'(active_mask), 32'b1101);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    test_all_pass();
    test_boundary();
    test_schemes();
    test_div3();
    test_switch();
    test_none();
    test_agents();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule